// File: doc/BRIEF.md
# Flash Write Protection Controller

This block guards every modifying operation of a 128 KiB serial flash array. It holds the write-enable latch and the protection fields of the status register. For each program, erase or status-register write request it decides whether the operation may go ahead, and it answers with a one-cycle grant or deny pulse. The command decoder supplies the inputs: the decoded latch set and clear commands, status-write requests with their data, and program or erase requests with an inclusive target address range or a whole-array flag. The external write-protect pin and chip select are sampled on the system clock.

Software protection covers an upper part of the array whose size is picked by a 3-bit field. An enable bit decides whether the hardware pin takes part at all. A status write is held pending while chip select stays low, and it is committed when chip select rises. It then runs as an internal cycle of a fixed length, and the pin has no effect on it.

Top module: `flash_wprot_ctrl`

## Requirements
- R1: After reset the status readback is 8'h00 and all four grant and deny outputs are low.
- R2: The write-enable latch sets in the cycle after the set command and clears in the cycle after the clear command. Clear wins when both arrive together.
- R3: A program, erase or status-write request that arrives while the latch is clear is denied. A denied status write leaves the status fields unchanged.
- R4: Protection field values 1 to 5 protect the upper 1/32, 1/16, 1/8, 1/4 and 1/2 of the array. Values 6 and 7 protect all of it, and 0 protects nothing. A program or erase is denied if its range reaches into the protected region, or if its start address is above its end address.
- R5: A whole-array erase is denied whenever the protection field is not 0.
- R6: When the pin enable bit is 1 and the pin is low, a status-write request is denied.
- R7: When the pin enable bit is 0, the pin level has no effect on status writes.
- R8: A pending status write whose chip select is still low is aborted, with a deny pulse, if the pin is low while the enable bit is 1. The status fields stay unchanged.
- R9: When chip select rises on a pending write, a grant pulse is issued. The busy bit is then 1 for exactly SR_CYC cycles, and the new fields appear when it falls. A low pin during this time has no effect.
- R10: The latch is clear after every program or erase decision, after every status-write deny or abort, and at the end of every status-write cycle.
- R11: A program or erase request is denied while a status write is pending or busy.
- R12: The status readback layout is bit 7 pin enable, bits 4:2 protection field, bit 1 latch, bit 0 busy. The other bits read 0, and a status write takes the new values from bits 7 and 4:2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wp_n | input | 1 | Write-protect pin, low protects |
| cs_n | input | 1 | Chip select, low while a command is in progress |
| cmd_wren | input | 1 | Decoded latch set command |
| cmd_wrdi | input | 1 | Decoded latch clear command |
| sr_wr_req | input | 1 | Status-write request pulse |
| sr_wr_data | input | 8 | Status-write data |
| pe_req | input | 1 | Program or erase request pulse |
| pe_chip | input | 1 | Request is a whole-array erase |
| pe_start | input | ADDR_W | First byte address of the target range |
| pe_end | input | ADDR_W | Last byte address of the target range |
| pe_grant | output | 1 | Program or erase allowed |
| pe_deny | output | 1 | Program or erase refused |
| sr_grant | output | 1 | Status-write cycle started |
| sr_deny | output | 1 | Status write refused or aborted |
| sr_rdata | output | 8 | Status register readback |

## Verification
The assertions assume that every request is a single-cycle pulse and that a status-write request arrives with chip select low. They also assume the decoder never asserts a program or erase request in the same cycle as a status-write request. The stimulus respects all of this. Each operation is driven as an isolated one-cycle pulse, and chip select is raised only after the status request has been taken. The pin is moved only at chosen points: while a write is pending to test the abort, and while one is busy to show it has no effect.

// File: rtl/flash_wprot_ctrl.sv
module flash_wprot_ctrl #(
  parameter int ADDR_W = 17,
  parameter int SR_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n,
  input  logic              cs_n,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              sr_wr_req,
  input  logic [7:0]        sr_wr_data,
  input  logic              pe_req,
  input  logic              pe_chip,
  input  logic [ADDR_W-1:0] pe_start,
  input  logic [ADDR_W-1:0] pe_end,
  output logic              pe_grant,
  output logic              pe_deny,
  output logic              sr_grant,
  output logic              sr_deny,
  output logic [7:0]        sr_rdata
);
  localparam int CNT_W = $clog2(SR_CYC + 1);
  localparam logic [ADDR_W-1:0] ALL_ONES = '1;

  logic             wel, wpen, busy, pend, wpen_new;
  logic [2:0]       bp, bp_new;
  logic [CNT_W-1:0] cnt;
  logic [ADDR_W-1:0] prot_base;
  logic             overlap, pe_ok;
  logic             unused_sr_bits;

  assign unused_sr_bits = ^{sr_wr_data[6:5], sr_wr_data[1:0]};

  wire hw_lock = wpen && !wp_n;

  always_comb begin
    prot_base = ALL_ONES << (ADDR_W - 6 + int'(bp));
    if (bp == 3'd0)      overlap = 1'b0;
    else if (bp >= 3'd6) overlap = 1'b1;
    else                 overlap = (pe_end >= prot_base);
  end

  assign pe_ok = wel && !busy && !pend &&
                 (pe_chip ? (bp == 3'd0) : (!overlap && pe_start <= pe_end));

  assign sr_rdata = {wpen, 2'b00, bp, wel, busy};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wel <= 1'b0; wpen <= 1'b0; bp <= '0; busy <= 1'b0; pend <= 1'b0;
      wpen_new <= 1'b0; bp_new <= '0; cnt <= '0;
      pe_grant <= 1'b0; pe_deny <= 1'b0; sr_grant <= 1'b0; sr_deny <= 1'b0;
    end else begin
      pe_grant <= 1'b0; pe_deny <= 1'b0; sr_grant <= 1'b0; sr_deny <= 1'b0;

      if (cmd_wrdi)      wel <= 1'b0;
      else if (cmd_wren) wel <= 1'b1;

      if (pe_req) begin
        pe_grant <= pe_ok;
        pe_deny  <= !pe_ok;
        wel      <= 1'b0;
      end

      if (pend) begin
        if (hw_lock) begin
          pend <= 1'b0; sr_deny <= 1'b1; wel <= 1'b0;
        end else if (cs_n) begin
          pend <= 1'b0; busy <= 1'b1; sr_grant <= 1'b1;
          cnt  <= CNT_W'(SR_CYC);
        end
      end else if (sr_wr_req) begin
        if (wel && !busy && !hw_lock) begin
          pend     <= 1'b1;
          wpen_new <= sr_wr_data[7];
          bp_new   <= sr_wr_data[4:2];
        end else begin
          sr_deny <= 1'b1; wel <= 1'b0;
        end
      end

      if (busy) begin
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          busy <= 1'b0; wpen <= wpen_new; bp <= bp_new; wel <= 1'b0;
        end
      end
    end
  end

  // R3
  nowel_pe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pe_req && !wel |=> pe_deny && !pe_grant);

  // R5
  chip_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pe_req && pe_chip && bp != 3'd0 |=> pe_deny);

  // R6
  hw_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr_req && !pend && wpen && !wp_n |=> sr_deny && !sr_grant);

  // R2
  wrdi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wrdi |=> !wel);

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cnt != CNT_W'(1) |=> busy && $stable(bp) && $stable(wpen));

  // R10
  pe_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pe_req |=> !wel);
endmodule

// File: tb/tb_flash_wprot_ctrl.sv
module tb_flash_wprot_ctrl;
  localparam int ADDR_W = 17;
  localparam int SR_CYC = 8;

  logic clk = 1'b0, rst_n = 1'b0, wp_n = 1'b1, cs_n = 1'b1;
  logic cmd_wren = 1'b0, cmd_wrdi = 1'b0, sr_wr_req = 1'b0, pe_req = 1'b0, pe_chip = 1'b0;
  logic [7:0] sr_wr_data = '0;
  logic [ADDR_W-1:0] pe_start = '0, pe_end = '0;
  logic pe_grant, pe_deny, sr_grant, sr_deny;
  logic [7:0] sr_rdata;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  flash_wprot_ctrl #(.ADDR_W(ADDR_W), .SR_CYC(SR_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .cs_n(cs_n),
    .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
    .sr_wr_req(sr_wr_req), .sr_wr_data(sr_wr_data),
    .pe_req(pe_req), .pe_chip(pe_chip), .pe_start(pe_start), .pe_end(pe_end),
    .pe_grant(pe_grant), .pe_deny(pe_deny), .sr_grant(sr_grant), .sr_deny(sr_deny),
    .sr_rdata(sr_rdata));

  // {bp, start, end, chip, expected grant}
  localparam logic [38:0] VEC [13] = '{
    {3'd0, 17'h00000, 17'h1FFFF, 1'b0, 1'b1},
    {3'd0, 17'h00000, 17'h00000, 1'b1, 1'b1},
    {3'd1, 17'h1EFF0, 17'h1EFFF, 1'b0, 1'b1},
    {3'd1, 17'h1EFF0, 17'h1F000, 1'b0, 1'b0},
    {3'd2, 17'h1DFFF, 17'h1DFFF, 1'b0, 1'b1},
    {3'd2, 17'h1E000, 17'h1E000, 1'b0, 1'b0},
    {3'd3, 17'h1BF00, 17'h1BFFF, 1'b0, 1'b1},
    {3'd4, 17'h18000, 17'h18000, 1'b0, 1'b0},
    {3'd5, 17'h0FFFF, 17'h0FFFF, 1'b0, 1'b1},
    {3'd5, 17'h10000, 17'h10000, 1'b0, 1'b0},
    {3'd5, 17'h00000, 17'h00000, 1'b1, 1'b0},
    {3'd6, 17'h00000, 17'h00000, 1'b0, 1'b0},
    {3'd7, 17'h00100, 17'h00100, 1'b0, 1'b0}
  };

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wren();
    cmd_wren = 1'b1; cyc(); cmd_wren = 1'b0;
  endtask

  task automatic sr_req(input logic [7:0] d);
    cs_n = 1'b0; sr_wr_req = 1'b1; sr_wr_data = d; cyc(); sr_wr_req = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (sr_rdata[0] && n < 1000) begin cyc(); n++; end
  endtask

  task automatic set_sr(input logic [7:0] d);
    int n;
    wren(); sr_req(d); cs_n = 1'b1; cyc(); wait_idle(n);
  endtask

  task automatic pe(input logic [ADDR_W-1:0] s, input logic [ADDR_W-1:0] e, input logic c);
    pe_req = 1'b1; pe_start = s; pe_end = e; pe_chip = c; cyc(); pe_req = 1'b0; pe_chip = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) cyc();
    rst_n = 1'b1; cyc();
    // R1
    chk("R1 rdata", sr_rdata, 8'h00);
    chk("R1 outs", {pe_grant, pe_deny, sr_grant, sr_deny}, 4'b0);

    // R2
    wren(); chk("R2 set", sr_rdata[1], 1'b1);
    cmd_wren = 1'b1; cmd_wrdi = 1'b1; cyc(); cmd_wren = 1'b0; cmd_wrdi = 1'b0;
    chk("R2 both", sr_rdata[1], 1'b0);
    wren(); cmd_wrdi = 1'b1; cyc(); cmd_wrdi = 1'b0;
    chk("R2 clear", sr_rdata[1], 1'b0);

    // R3
    pe(17'h0, 17'h0, 1'b0);
    chk("R3 pe nowel", {pe_grant, pe_deny}, 2'b01);
    sr_req(8'h0C); cs_n = 1'b1;
    chk("R3 sr nowel", {sr_grant, sr_deny}, 2'b01);
    cyc(); chk("R3 sr unchanged", sr_rdata, 8'h00);

    // R4 R5 R10 table
    for (int i = 0; i < 13; i++) begin
      logic [38:0] v;
      v = VEC[i];
      set_sr({3'b000, v[38:36], 2'b00});
      wren();
      pe(v[35:19], v[18:2], v[1]);
      chk(v[1] ? "R5 chip erase" : "R4 range", {pe_grant, pe_deny}, {v[0], ~v[0]});
      chk("R10 wel after pe", sr_rdata[1], 1'b0);
    end
    set_sr(8'h00);
    wren(); pe(17'h00010, 17'h0000F, 1'b0);
    chk("R4 reversed range", {pe_grant, pe_deny}, 2'b01);

    // R7: pin low, enable 0
    wp_n = 1'b0;
    wren(); sr_req(8'h0C);
    chk("R7 no deny", sr_deny, 1'b0);
    cs_n = 1'b1; cyc();
    chk("R7 grant", sr_grant, 1'b1);
    wait_idle(n);
    chk("R7 rdata", sr_rdata, 8'h0C);
    wp_n = 1'b1;

    // R12 layout, enable bit set
    set_sr(8'hFF);
    chk("R12 layout", sr_rdata, 8'h9C);
    set_sr(8'h80);
    chk("R12 enable only", sr_rdata, 8'h80);

    // R6
    wp_n = 1'b0;
    wren(); sr_req(8'h84); cs_n = 1'b1;
    chk("R6 deny", {sr_grant, sr_deny}, 2'b01);
    cyc(); chk("R6 unchanged", sr_rdata, 8'h80);
    wp_n = 1'b1;

    // R8 abort while pending
    wren(); sr_req(8'h84);
    chk("R8 pending", {sr_grant, sr_deny}, 2'b00);
    wp_n = 1'b0; cyc();
    chk("R8 abort", {sr_grant, sr_deny}, 2'b01);
    cs_n = 1'b1; cyc();
    chk("R8 unchanged", sr_rdata, 8'h80);
    wp_n = 1'b1;

    // R9 cycle length and pin ignored while busy
    wren(); sr_req(8'h00); cs_n = 1'b1; cyc();
    chk("R9 grant", sr_grant, 1'b1);
    wp_n = 1'b0;
    wait_idle(n);
    chk("R9 length", n, SR_CYC);
    chk("R9 committed", sr_rdata, 8'h00);
    wp_n = 1'b1;

    // R11 request while busy, R10 end of cycle
    wren(); sr_req(8'h04); cs_n = 1'b1; cyc();
    pe(17'h0, 17'h0, 1'b0);
    chk("R11 busy deny", {pe_grant, pe_deny}, 2'b01);
    wait_idle(n);
    chk("R10 wel at end", sr_rdata, 8'h04);
    wren(); sr_req(8'h00);
    pe(17'h0, 17'h0, 1'b0);
    chk("R11 pending deny", {pe_grant, pe_deny}, 2'b01);
    cs_n = 1'b1; cyc(); wait_idle(n);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule